// File: doc/BRIEF.md
# Threshold Scan Scaler Array

This block runs the calibration scan for a bank of discriminator channels. Software programs a threshold range, a pulse count per channel, a settling delay and a mask of the enabled channels, then issues a one-cycle start. The block drives the threshold code and waits for the settling delay. It then lights the calibration LED of one enabled channel at a time, in ascending channel order, for the programmed number of strobes. During that window it counts the rising edges on that channel's discriminator line.

Every discriminator line passes through a two-flop synchronizer and an edge detector. Only the illuminated channel's counter may advance. The counter stops at its maximum value and does not wrap. A channel's count is cleared just before that channel is lit. After the channel's last strobe and its drain gap, the block emits one result word holding the threshold code, the channel index and the count. Disabled channels are passed over without strobes and without results. When the last channel of the last threshold has been reported, a done flag rises and stays high until the next start.

Top module: `thr_scan_scaler`

## Requirements
- R1: While reset is high and in the first cycle after it, led_strobe, res_valid, busy and done are all 0.
- R2: The threshold code starts at thr_first and rises by one after each full channel pass, up to and including thr_last. If thr_last is below thr_first, only thr_first is scanned.
- R3: After each change of thr_code, led_strobe stays low for at least settle_cycles clock cycles.
- R4: Each enabled channel receives exactly max(pulses_per_ch,1) strobes, each STROBE_LEN cycles high, and led_sel does not change while led_strobe is high.
- R5: A channel whose ch_enable bit is 0 is never strobed and produces no result word. With no channel enabled, the scan produces no strobe and no result.
- R6: Only edges on the channel selected by led_sel are counted. Pulses on all other channels have no effect on any result.
- R7: Counting is on rising edges of the synchronized line only, so a long pulse counts once and a pair of short pulses counts twice.
- R8: A count that reaches 2^CNT_W-1 holds that value for further edges and does not wrap.
- R9: After the drain gap of an enabled channel's last strobe, res_valid is high for exactly one cycle. res_thr, res_ch and res_count then hold the threshold, the channel and that channel's edge count for the current threshold. Words arrive in threshold-major, ascending-channel order.
- R10: done rises the cycle after the last result of the last threshold (or after the last skipped channel), busy falls with it, and done stays high until the next accepted start.
- R11: Each count covers only the current channel and threshold, because the counter is cleared before the channel is lit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle scan start, accepted when idle |
| thr_first | input | THR_W | First threshold code |
| thr_last | input | THR_W | Last threshold code (inclusive) |
| pulses_per_ch | input | NPULSE_W | LED strobes per channel (0 acts as 1) |
| settle_cycles | input | SETTLE_W | Minimum wait after a threshold change |
| ch_enable | input | NUM_CH | One bit per channel, 1 = include in scan |
| disc_in | input | NUM_CH | Asynchronous discriminator lines |
| thr_code | output | THR_W | Threshold code driven to the DAC |
| led_sel | output | log2(NUM_CH) | Index of the illuminated channel |
| led_strobe | output | 1 | LED fire strobe |
| res_valid | output | 1 | Result word valid (one cycle) |
| res_thr | output | THR_W | Threshold of the result |
| res_ch | output | log2(NUM_CH) | Channel of the result |
| res_count | output | CNT_W | Rising-edge count of the result |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Scan complete, held until next start |

## Verification
A corrupted channel index or enable mask shows up at the first strobe, as a strobe on a disabled channel or a result word out of order. A counter that is not cleared, counts a neighbour's noise, counts pulse width instead of edges, or wraps shows up in the very next result word, one drain gap after the last strobe, as a count that differs from the modelled response. A broken threshold step or settling timer is visible at the first strobe after the threshold changes. A lost end-of-scan state shows as a missing or early done.

// File: rtl/thr_scan_pkg.sv
package thr_scan_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_SEEK,
        ST_ARM,
        ST_STROBE,
        ST_GAP,
        ST_EMIT
    } scan_state_e;

    // cycles with the LED channel selected but counting off, flushing the synchronizer
    localparam int ARM_LEN = 4;

    // true when the pulse just finished is the last one for the channel; zero acts as one
    function automatic logic final_pulse(input int unsigned pcnt, input int unsigned npulse);
        return (pcnt + 1) >= npulse;
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/scan_sync_edge.sv
module scan_sync_edge #(
    parameter int NUM_CH = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] line_in,
    output logic [NUM_CH-1:0] rise
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic meta_q, sync_q, last_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                last_q <= 1'b0;
            end else begin
                meta_q <= line_in[i];
                sync_q <= meta_q;
                last_q <= sync_q;
            end
        end
        assign rise[i] = sync_q & ~last_q;
    end
endmodule

// File: rtl/scan_counter_bank.sv
module scan_counter_bank #(
    parameter int NUM_CH = 64,
    parameter int CNT_W  = 16,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              en,
    input  logic [CH_W-1:0]   sel,
    input  logic [NUM_CH-1:0] rise,
    output logic [CNT_W-1:0]  sel_count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [NUM_CH*CNT_W-1:0] flat;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_cnt
        logic [CNT_W-1:0] cnt_q;
        logic             mine;
        assign mine = (sel == CH_W'(i));
        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q <= '0;
            end else if (clr && mine) begin
                cnt_q <= '0;
            end else if (en && mine && rise[i] && cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
        assign flat[i*CNT_W +: CNT_W] = cnt_q;
    end

    always_comb begin
        sel_count = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (sel == CH_W'(i)) sel_count = flat[i*CNT_W +: CNT_W];
        end
    end
endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
    import thr_scan_pkg::*;
#(
    parameter int NUM_CH     = 64,
    parameter int THR_W      = 8,
    parameter int SETTLE_W   = 16,
    parameter int NPULSE_W   = 8,
    parameter int STROBE_LEN = 4,
    parameter int GAP_LEN    = 16,
    localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [THR_W-1:0]    thr_first,
    input  logic [THR_W-1:0]    thr_last,
    input  logic [NPULSE_W-1:0] pulses_per_ch,
    input  logic [SETTLE_W-1:0] settle_cycles,
    input  logic [NUM_CH-1:0]   ch_enable,
    output logic [THR_W-1:0]    thr_code,
    output logic [CH_W-1:0]     led_sel,
    output logic                led_strobe,
    output logic                cnt_en,
    output logic                cnt_clr,
    output logic                res_valid,
    output logic                busy,
    output logic                done,
    output logic [NUM_CH-1:0]   mask_q,
    output logic [SETTLE_W-1:0] settle_q
);
    localparam int PHASE_MAX = max3(STROBE_LEN, GAP_LEN, ARM_LEN);
    localparam int PH_W      = $clog2(PHASE_MAX + 1);
    localparam int TMR_W     = (SETTLE_W > PH_W) ? SETTLE_W : PH_W;
    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

    scan_state_e         state_q;
    logic [THR_W-1:0]    thr_q, last_q;
    logic [CH_W-1:0]     ch_q;
    logic [TMR_W-1:0]    tmr_q;
    logic [NPULSE_W-1:0] pcnt_q, np_q;
    logic                scan_end;
    logic                ch_on;

    assign scan_end = (thr_q >= last_q);
    assign ch_on    = mask_q[ch_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            thr_q    <= '0;
            last_q   <= '0;
            ch_q     <= '0;
            tmr_q    <= '0;
            pcnt_q   <= '0;
            np_q     <= '0;
            mask_q   <= '0;
            settle_q <= '0;
            done     <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        thr_q    <= thr_first;
                        last_q   <= thr_last;
                        np_q     <= pulses_per_ch;
                        settle_q <= settle_cycles;
                        mask_q   <= ch_enable;
                        done     <= 1'b0;
                        tmr_q    <= '0;
                        state_q  <= ST_SETTLE;
                    end
                end
                ST_SETTLE: begin
                    if (tmr_q == TMR_W'(settle_q)) begin
                        ch_q    <= '0;
                        state_q <= ST_SEEK;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                ST_SEEK: begin
                    if (ch_on) begin
                        tmr_q   <= '0;
                        state_q <= ST_ARM;
                    end else if (ch_q == LAST_CH) begin
                        if (scan_end) begin
                            state_q <= ST_IDLE;
                            done    <= 1'b1;
                        end else begin
                            thr_q   <= thr_q + 1'b1;
                            tmr_q   <= '0;
                            state_q <= ST_SETTLE;
                        end
                    end else begin
                        ch_q <= ch_q + 1'b1;
                    end
                end
                ST_ARM: begin
                    if (tmr_q == TMR_W'(ARM_LEN - 1)) begin
                        tmr_q   <= '0;
                        pcnt_q  <= '0;
                        state_q <= ST_STROBE;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                ST_STROBE: begin
                    if (tmr_q == TMR_W'(STROBE_LEN - 1)) begin
                        tmr_q   <= '0;
                        state_q <= ST_GAP;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                ST_GAP: begin
                    if (tmr_q == TMR_W'(GAP_LEN - 1)) begin
                        tmr_q <= '0;
                        if (final_pulse(32'(pcnt_q), 32'(np_q))) begin
                            state_q <= ST_EMIT;
                        end else begin
                            pcnt_q  <= pcnt_q + 1'b1;
                            state_q <= ST_STROBE;
                        end
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                ST_EMIT: begin
                    if (ch_q == LAST_CH) begin
                        if (scan_end) begin
                            state_q <= ST_IDLE;
                            done    <= 1'b1;
                        end else begin
                            thr_q   <= thr_q + 1'b1;
                            tmr_q   <= '0;
                            state_q <= ST_SETTLE;
                        end
                    end else begin
                        ch_q    <= ch_q + 1'b1;
                        state_q <= ST_SEEK;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign thr_code   = thr_q;
    assign led_sel    = ch_q;
    assign led_strobe = (state_q == ST_STROBE);
    assign cnt_en     = (state_q == ST_STROBE) || (state_q == ST_GAP);
    assign cnt_clr    = (state_q == ST_SEEK) && ch_on;
    assign res_valid  = (state_q == ST_EMIT);
    assign busy       = (state_q != ST_IDLE);
endmodule

// File: rtl/thr_scan_scaler.sv
module thr_scan_scaler #(
    parameter int NUM_CH     = 64,
    parameter int CNT_W      = 16,
    parameter int THR_W      = 8,
    parameter int SETTLE_W   = 16,
    parameter int NPULSE_W   = 8,
    parameter int STROBE_LEN = 4,
    parameter int GAP_LEN    = 16,
    localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [THR_W-1:0]    thr_first,
    input  logic [THR_W-1:0]    thr_last,
    input  logic [NPULSE_W-1:0] pulses_per_ch,
    input  logic [SETTLE_W-1:0] settle_cycles,
    input  logic [NUM_CH-1:0]   ch_enable,
    input  logic [NUM_CH-1:0]   disc_in,
    output logic [THR_W-1:0]    thr_code,
    output logic [CH_W-1:0]     led_sel,
    output logic                led_strobe,
    output logic                res_valid,
    output logic [THR_W-1:0]    res_thr,
    output logic [CH_W-1:0]     res_ch,
    output logic [CNT_W-1:0]    res_count,
    output logic                busy,
    output logic                done
);
    logic [NUM_CH-1:0]   rise;
    logic                cnt_en, cnt_clr;
    logic [NUM_CH-1:0]   mask_q;
    logic [SETTLE_W-1:0] settle_q;

    scan_sync_edge #(.NUM_CH(NUM_CH)) sync_i (
        .clk     (clk),
        .rst     (rst),
        .line_in (disc_in),
        .rise    (rise)
    );

    scan_sequencer #(
        .NUM_CH     (NUM_CH),
        .THR_W      (THR_W),
        .SETTLE_W   (SETTLE_W),
        .NPULSE_W   (NPULSE_W),
        .STROBE_LEN (STROBE_LEN),
        .GAP_LEN    (GAP_LEN)
    ) seq_i (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .thr_first     (thr_first),
        .thr_last      (thr_last),
        .pulses_per_ch (pulses_per_ch),
        .settle_cycles (settle_cycles),
        .ch_enable     (ch_enable),
        .thr_code      (thr_code),
        .led_sel       (led_sel),
        .led_strobe    (led_strobe),
        .cnt_en        (cnt_en),
        .cnt_clr       (cnt_clr),
        .res_valid     (res_valid),
        .busy          (busy),
        .done          (done),
        .mask_q        (mask_q),
        .settle_q      (settle_q)
    );

    scan_counter_bank #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) bank_i (
        .clk       (clk),
        .rst       (rst),
        .clr       (cnt_clr),
        .en        (cnt_en),
        .sel       (led_sel),
        .rise      (rise),
        .sel_count (res_count)
    );

    assign res_thr = thr_code;
    assign res_ch  = led_sel;
endmodule

// File: rtl/thr_scan_scaler_chk.sv
module thr_scan_scaler_chk #(
    parameter int NUM_CH   = 64,
    parameter int CNT_W    = 16,
    parameter int THR_W    = 8,
    parameter int SETTLE_W = 16,
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input logic                clk,
    input logic                rst,
    input logic                led_strobe,
    input logic [CH_W-1:0]     led_sel,
    input logic [THR_W-1:0]    thr_code,
    input logic                res_valid,
    input logic [CNT_W-1:0]    res_count,
    input logic                busy,
    input logic                done,
    input logic                cnt_en,
    input logic                cnt_clr,
    input logic [NUM_CH-1:0]   mask_q,
    input logic [SETTLE_W-1:0] settle_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [THR_W-1:0]  prev_thr;
    logic [SETTLE_W:0] since_thr;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_thr  <= '0;
            since_thr <= '0;
        end else begin
            prev_thr <= thr_code;
            if (thr_code != prev_thr) since_thr <= '0;
            else if (~&since_thr)     since_thr <= since_thr + 1'b1;
        end
    end

    AST_STROBE_ENABLED: assert property (@(posedge clk) disable iff (rst)
        led_strobe |-> mask_q[led_sel]);                                        // R5
    AST_SEL_HELD: assert property (@(posedge clk) disable iff (rst)
        (led_strobe && $past(led_strobe)) |-> $stable(led_sel));                // R4
    AST_SETTLE_WAIT: assert property (@(posedge clk) disable iff (rst)
        $rose(led_strobe) |-> (since_thr >= {1'b0, settle_q}));                 // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (res_count == CNT_MAX && !cnt_clr) |=>
            (res_count == CNT_MAX || led_sel != $past(led_sel)));               // R8
    AST_QUIET_COUNT: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en && !cnt_clr) |=> ($stable(res_count) || led_sel != $past(led_sel))); // R6
    AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);                                              // R9
    AST_RESULT_THR_HELD: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $stable(thr_code));                                       // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !led_strobe && !res_valid));                         // R10
endmodule

bind thr_scan_scaler thr_scan_scaler_chk #(
    .NUM_CH   (NUM_CH),
    .CNT_W    (CNT_W),
    .THR_W    (THR_W),
    .SETTLE_W (SETTLE_W)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .led_strobe (led_strobe),
    .led_sel    (led_sel),
    .thr_code   (thr_code),
    .res_valid  (res_valid),
    .res_count  (res_count),
    .busy       (busy),
    .done       (done),
    .cnt_en     (cnt_en),
    .cnt_clr    (cnt_clr),
    .mask_q     (mask_q),
    .settle_q   (settle_q)
);

// File: tb/thr_scan_scaler_tb_top.sv
module thr_scan_scaler_tb_top;
    localparam int NUM_CH     = 64;
    localparam int CNT_W      = 4;
    localparam int THR_W      = 8;
    localparam int SETTLE_W   = 8;
    localparam int NPULSE_W   = 8;
    localparam int STROBE_LEN = 2;
    localparam int GAP_LEN    = 12;
    localparam int CH_W       = $clog2(NUM_CH);
    localparam int CNT_MAX    = (1 << CNT_W) - 1;

    typedef struct {
        int thr;
        int ch;
        int cnt;
    } exp_item_t;

    logic                clk = 1'b0;
    logic                rst;
    logic                start;
    logic [THR_W-1:0]    thr_first, thr_last;
    logic [NPULSE_W-1:0] pulses_per_ch;
    logic [SETTLE_W-1:0] settle_cycles;
    logic [NUM_CH-1:0]   ch_enable;
    logic [NUM_CH-1:0]   disc_in;
    logic [THR_W-1:0]    thr_code;
    logic [CH_W-1:0]     led_sel;
    logic                led_strobe, res_valid, busy, done;
    logic [THR_W-1:0]    res_thr;
    logic [CH_W-1:0]     res_ch;
    logic [CNT_W-1:0]    res_count;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    int strobes_total = 0;
    int cur_np = 1;
    int cur_settle = 0;
    exp_item_t exp_q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    thr_scan_scaler #(
        .NUM_CH(NUM_CH), .CNT_W(CNT_W), .THR_W(THR_W), .SETTLE_W(SETTLE_W),
        .NPULSE_W(NPULSE_W), .STROBE_LEN(STROBE_LEN), .GAP_LEN(GAP_LEN)
    ) dut_i (
        .clk(clk), .rst(rst), .start(start), .thr_first(thr_first), .thr_last(thr_last),
        .pulses_per_ch(pulses_per_ch), .settle_cycles(settle_cycles), .ch_enable(ch_enable),
        .disc_in(disc_in), .thr_code(thr_code), .led_sel(led_sel), .led_strobe(led_strobe),
        .res_valid(res_valid), .res_thr(res_thr), .res_ch(res_ch), .res_count(res_count),
        .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // discriminator response model: channel fires while threshold is below its level
    function automatic int level_of(input int ch);
        return 4 + (ch * 3) % 4;
    endfunction
    function automatic int edges_of(input int ch);
        return (ch % 5 == 0) ? 2 : 1;   // double short pulse -> two edges
    endfunction
    function automatic int expect_count(input int thr, input int ch, input int np);
        int n;
        n = (np < 1) ? 1 : np;
        if (thr >= level_of(ch)) return 0;
        n = n * edges_of(ch);
        return (n > CNT_MAX) ? CNT_MAX : n;
    endfunction

    // stimulus model, driven away from the active edge
    initial begin
        int  act_ch;
        int  k;
        bit  prev_stb;
        logic [NUM_CH-1:0] v;
        disc_in  = '0;
        act_ch   = 0;
        k        = -1;
        prev_stb = 1'b0;
        forever begin
            @(negedge clk);
            if (led_strobe && !prev_stb && int'(thr_code) < level_of(int'(led_sel))) begin
                act_ch = int'(led_sel);
                k = 0;
            end
            prev_stb = led_strobe;
            v = '0;
            for (int c = 0; c < NUM_CH; c++) begin
                if (c != int'(led_sel) && (cyc % 6 == 0)) v[c] = 1'b1;   // foreign noise
            end
            if (k >= 0) begin
                if (act_ch % 5 == 0)      v[act_ch] = (k < 2) || (k == 4) || (k == 5);
                else if (act_ch % 3 == 1) v[act_ch] = (k < 7);            // long monostable
                else                      v[act_ch] = (k < 2);
                k = (k >= 8) ? -1 : k + 1;
            end
            disc_in = v;
        end
    end

    // monitor / scoreboard
    initial begin
        int  stb_in_ch = 0;
        int  width = 0;
        int  since = 0;
        bit  prev_stb = 1'b0;
        logic [THR_W-1:0] last_thr = '0;
        exp_item_t e;
        forever begin
            @(negedge clk);
            if (rst) begin
                prev_stb = 1'b0;
                last_thr = thr_code;
                since = 0;
                continue;
            end
            if (thr_code != last_thr) since = 0; else since++;
            last_thr = thr_code;
            if (led_strobe && !prev_stb) begin
                stb_in_ch++;
                strobes_total++;
                check(since >= cur_settle, "R3 settle before strobe", since, cur_settle);
                check(ch_enable[led_sel] == 1'b1, "R5 strobe on disabled channel",
                      int'(led_sel), -1);
            end
            if (led_strobe) width++;
            if (!led_strobe && prev_stb) begin
                check(width == STROBE_LEN, "R4 strobe width", width, STROBE_LEN);
                width = 0;
            end
            prev_stb = led_strobe;
            if (res_valid) begin
                check(stb_in_ch == cur_np, "R4 strobes per channel", stb_in_ch, cur_np);
                stb_in_ch = 0;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected result word", int'(res_ch), -1);
                end else begin
                    e = exp_q.pop_front();
                    check(int'(res_thr) == e.thr, "R2 result threshold", int'(res_thr), e.thr);
                    check(int'(res_ch) == e.ch, "R5 R9 result channel order", int'(res_ch), e.ch);
                    check(int'(res_count) == e.cnt, "R6 R7 R8 R11 result count",
                          int'(res_count), e.cnt);
                end
            end
        end
    end

    task automatic run_scan(input int first, input int last, input int np, input int settle,
                            input logic [NUM_CH-1:0] mask);
        int t;
        int guard;
        t = first;
        forever begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (mask[c]) begin
                    exp_item_t e;
                    e.thr = t;
                    e.ch  = c;
                    e.cnt = expect_count(t, c, np);
                    exp_q.push_back(e);
                end
            end
            if (t >= last) break;
            t++;
        end
        @(negedge clk);
        thr_first     = THR_W'(first);
        thr_last      = THR_W'(last);
        pulses_per_ch = NPULSE_W'(np);
        settle_cycles = SETTLE_W'(settle);
        ch_enable     = mask;
        cur_np        = (np < 1) ? 1 : np;
        cur_settle    = settle;
        start         = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0, "R10 done cleared by start", int'(done), 0);
        guard = 0;
        while (!(done && !busy) && guard < 60000) begin
            @(negedge clk);
            guard++;
        end
        check(done == 1'b1 && busy == 1'b0, "R10 done at end of scan", int'(done), 1);
        check(exp_q.size() == 0, "R9 all result words seen", exp_q.size(), 0);
        exp_q.delete();
        repeat (5) @(negedge clk);
        check(done == 1'b1 && busy == 1'b0 && !led_strobe, "R10 done held", int'(done), 1);
    endtask

    initial begin
        logic [NUM_CH-1:0] m1;
        int s0;
        rst           = 1'b1;
        start         = 1'b0;
        thr_first     = '0;
        thr_last      = '0;
        pulses_per_ch = '0;
        settle_cycles = '0;
        ch_enable     = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(!led_strobe && !res_valid && !busy && !done, "R1 reset state in reset",
              {led_strobe, res_valid, busy, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!led_strobe && !res_valid && !busy && !done, "R1 reset state after reset",
              {led_strobe, res_valid, busy, done}, 0);

        for (int c = 0; c < NUM_CH; c++) m1[c] = !((c % 7 == 3) || (c == NUM_CH - 1));
        // R2 R6 R7 R8 R11: four thresholds, saturating double pulses, masked channels
        run_scan(3, 6, 9, 20, m1);
        // R2: last below first scans only the first; R4: zero pulses acts as one
        run_scan(2, 1, 0, 3, '1);
        // R5: nothing enabled gives no strobe and no result
        s0 = strobes_total;
        run_scan(5, 6, 5, 2, '0);
        check(strobes_total == s0, "R5 no strobes with empty mask", strobes_total - s0, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual %0d expected %0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule